// File: doc/BRIEF.md
# Touch Converter Serial Frame Master

This block is the host side of a serial link to a touchscreen-style analogue-to-digital converter. A client presents one request that carries a three-bit channel select, a resolution mode bit, a reference select bit and two power-control bits. The master turns those fields into an eight-bit command word, lowers chip select, and produces the 24 serial clocks of one conversion frame. It returns the 12-bit conversion result, right-aligned, together with a one-cycle done strobe.

The serial clock is derived from the system clock. Each serial clock phase, high or low, lasts `DIV_HALF` system clocks. A per-request burst flag splits the 24 clocks into three groups of eight. Between groups the serial clock is held low for an extra `GAP_CYC` system clocks, which suits converters that a byte-oriented port feeds. The converter takes the command on the serial data output, spends one clock signalling busy, then shifts out twelve result bits followed by zero fill. The master samples its serial input on rising serial clock edges and keeps only the twelve result positions.

Top module: `tscm_master`

## Requirements
- R1: After reset, `csn_o` is high, `sclk_o` is low, `sdo_o` is low, `busy_o` and `done_o` are low, and `result_o` is zero.
- R2: An accepted request sends the command word MSB first on `sdo_o`, one bit per serial clock in this bit order: 1, chan[2], chan[1], chan[0], mode, ref_sel, pd[1], pd[0]. `sdo_o` changes only while `sclk_o` is low. `sdo_o` is low while `csn_o` is high.
- R3: Each frame has exactly 24 rising `sclk_o` edges, all with `csn_o` low. `csn_o` falls at least `DIV_HALF` system clocks before the first rising edge. `csn_o` stays low for at least `DIV_HALF` system clocks after the last falling edge.
- R4: With the burst flag clear, every high phase and every low phase of `sclk_o` inside a frame lasts exactly `DIV_HALF` system clocks.
- R5: With the burst flag set, the low phases after the 8th and 16th serial clocks last `DIV_HALF + GAP_CYC` system clocks. Every other phase lasts `DIV_HALF`.
- R6: `sdi_i` is sampled on rising serial clocks 10 to 21, counting from 1. The bit taken on clock 10 lands in `result_o[11]` and the bit taken on clock 21 lands in `result_o[0]`.
- R7: Values on `sdi_i` at rising serial clocks 1 to 9 and 22 to 24 have no effect on `result_o`.
- R8: A request is accepted only when `busy_o` is low. `busy_o` is high from the cycle after acceptance until the done cycle. A request raised while busy starts no frame and does not change the command word of the running frame.
- R9: `done_o` is high for exactly one system clock, in the cycle in which `csn_o` returns high. `result_o` carries the new result in that cycle and holds it until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a frame (taken when not busy) |
| chan_i | input | 3 | Channel select field of the command |
| mode_i | input | 1 | Resolution mode bit of the command |
| ref_sel_i | input | 1 | Reference select bit of the command |
| pd_i | input | 2 | Power-control field of the command |
| burst_i | input | 1 | 1: three 8-clock groups with gaps; 0: one continuous run |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| result_o | output | 12 | Last captured conversion result, right-aligned |
| sclk_o | output | 1 | Serial clock to the converter |
| csn_o | output | 1 | Active-low chip select |
| sdo_o | output | 1 | Serial command data to the converter |
| sdi_i | input | 1 | Serial result data from the converter |

## Verification
Every combination of the 8 channels, both mode bits, both reference settings and all four power-control codes is sent, once in continuous mode and once in burst mode. This shows that each command field reaches its bit position and that the grouping does not disturb the command. The converter model returns words derived from the command, plus all-zeros, all-ones, lone-MSB, lone-LSB and alternating patterns, so that a shifted or reversed capture window gives a wrong value. The model drives ones outside the result window, so a capture at clock 9 or at clocks 22 to 24 corrupts the word. Measured low-phase lengths tell the continuous and burst timing apart and confirm that the gaps fall after clocks 8 and 16. A request raised mid-frame shows that the busy interlock holds.

// File: rtl/tscm_pkg.sv
// Package: shared constants and helpers for the touch converter frame master.
// Assumes a fixed 24-clock frame with an 8-bit command and a 12-bit result.
package tscm_pkg;

    localparam int IDX_W = 5;
    localparam logic [IDX_W-1:0] FRAME_CLKS = 5'd24;
    localparam logic [IDX_W-1:0] GROUP_A_END = 5'd8;
    localparam logic [IDX_W-1:0] GROUP_B_END = 5'd16;
    localparam logic [IDX_W-1:0] RES_FIRST = 5'd10;
    localparam logic [IDX_W-1:0] RES_LAST = 5'd21;
    localparam int CMD_W = 8;
    localparam int RES_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } seq_state_t;

    // Assemble the command word: start bit first, power-control bits last.
    function automatic logic [CMD_W-1:0] make_cmd(input logic [2:0] ch, input logic md,
                                                 input logic rs, input logic [1:0] pd);
        return {1'b1, ch, md, rs, pd};
    endfunction

endpackage

// File: rtl/tscm_timer.sv
// Module: loadable phase timer. Load sets the phase length in system clocks
// (len >= 1); expire_o is high in the last cycle of the phase.
// Assumes the length never exceeds 2**CW-1.
module tscm_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    // Count the remaining cycles of the current phase down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/tscm_seq.sv
// Module: frame sequencer. Walks setup, 24 high/low serial clock phases and a
// tail phase. Drives chip select, the serial clock, the phase timer and the
// shift strobes. Assumes a phase timer whose expire marks the last cycle.
module tscm_seq
    import tscm_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int GAP_CYC  = 16,
    parameter int CW       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             burst_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [CW-1:0]    len_o,
    output logic             start_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             fin_o,
    output logic [IDX_W-1:0] rise_num_o,
    output logic             sclk_o,
    output logic             csn_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [CW-1:0] HALF_LEN = CW'(DIV_HALF);
    localparam logic [CW-1:0] GAP_LEN  = CW'(DIV_HALF + GAP_CYC);

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             burst_q;
    logic             grp_end;

    // Decode the phase transitions taken this cycle.
    always_comb begin
        start_o = (state_q == ST_IDLE) && req_i;
        rise_o  = ((state_q == ST_SETUP) || (state_q == ST_LOW)) && expire_i;
        fall_o  = (state_q == ST_HIGH) && expire_i;
        fin_o   = (state_q == ST_TAIL) && expire_i;
        load_o  = start_o || ((state_q != ST_IDLE) && expire_i);
        grp_end = burst_q && ((idx_q == GROUP_A_END) || (idx_q == GROUP_B_END));
        len_o   = (fall_o && grp_end) ? GAP_LEN : HALF_LEN;
    end

    assign rise_num_o = idx_q + 1'b1;
    assign busy_o     = (state_q != ST_IDLE);

    // Advance the frame state and the registered link outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            burst_q <= 1'b0;
            sclk_o  <= 1'b0;
            csn_o   <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        state_q <= ST_SETUP;
                        csn_o   <= 1'b0;
                        idx_q   <= '0;
                        burst_q <= burst_i;
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (expire_i) begin
                        state_q <= ST_HIGH;
                        sclk_o  <= 1'b1;
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (expire_i) begin
                        sclk_o  <= 1'b0;
                        state_q <= (idx_q == FRAME_CLKS) ? ST_TAIL : ST_LOW;
                    end
                end
                ST_TAIL: begin
                    if (expire_i) begin
                        state_q <= ST_IDLE;
                        csn_o   <= 1'b1;
                        done_o  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tscm_shift.sv
// Module: command shifter and result capture. Shifts the command out MSB first
// on each serial falling edge. Shifts the input in on rising clocks inside
// the result window and publishes the word at frame end.
module tscm_shift
    import tscm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             fin_i,
    input  logic [IDX_W-1:0] rise_num_i,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic [RES_W-1:0] result_o
);

    logic [CMD_W-1:0] tx_q;
    logic [RES_W-1:0] rx_q;
    logic             in_win;

    assign in_win = (rise_num_i >= RES_FIRST) && (rise_num_i <= RES_LAST);
    assign sdo_o  = tx_q[CMD_W-1];

    // Load the command at frame start and shift it on every falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (start_i) begin
            tx_q <= cmd_i;
        end else if (fall_i) begin
            tx_q <= {tx_q[CMD_W-2:0], 1'b0};
        end
    end

    // Collect result bits MSB first inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise_i && in_win) begin
            rx_q <= {rx_q[RES_W-2:0], sdi_i};
        end
    end

    // Publish the collected word at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (fin_i) begin
            result_o <= rx_q;
        end
    end

endmodule

// File: rtl/tscm_master.sv
// Module: top of the touch converter frame master. Accepts a command request,
// runs a 24-clock serial frame (continuous or in three 8-clock groups) and
// returns the 12-bit result with a done strobe. Assumes DIV_HALF >= 1.
module tscm_master
    import tscm_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int GAP_CYC  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [2:0]  chan_i,
    input  logic        mode_i,
    input  logic        ref_sel_i,
    input  logic [1:0]  pd_i,
    input  logic        burst_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [11:0] result_o,
    output logic        sclk_o,
    output logic        csn_o,
    output logic        sdo_o,
    input  logic        sdi_i
);

    localparam int CW = $clog2(DIV_HALF + GAP_CYC + 1);

    logic             t_load;
    logic [CW-1:0]    t_len;
    logic             t_expire;
    logic             s_start;
    logic             s_rise;
    logic             s_fall;
    logic             s_fin;
    logic [IDX_W-1:0] s_rise_num;
    logic [CMD_W-1:0] cmd_word;

    assign cmd_word = make_cmd(chan_i, mode_i, ref_sel_i, pd_i);

    tscm_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (t_load),
        .len_i    (t_len),
        .expire_o (t_expire)
    );

    tscm_seq #(.DIV_HALF(DIV_HALF), .GAP_CYC(GAP_CYC), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .burst_i    (burst_i),
        .expire_i   (t_expire),
        .load_o     (t_load),
        .len_o      (t_len),
        .start_o    (s_start),
        .rise_o     (s_rise),
        .fall_o     (s_fall),
        .fin_o      (s_fin),
        .rise_num_o (s_rise_num),
        .sclk_o     (sclk_o),
        .csn_o      (csn_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    tscm_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (s_start),
        .cmd_i      (cmd_word),
        .rise_i     (s_rise),
        .fall_i     (s_fall),
        .fin_i      (s_fin),
        .rise_num_i (s_rise_num),
        .sdi_i      (sdi_i),
        .sdo_o      (sdo_o),
        .result_o   (result_o)
    );

endmodule

// File: rtl/tscm_master_chk.sv
// Checker: protocol properties of the frame master, observed at its ports.
// Attached to every tscm_master instance by the bind at the end of this file.
module tscm_master_chk #(
    parameter int DIV_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic csn_o,
    input logic sdo_o,
    input logic busy_o,
    input logic done_o
);

    logic [15:0] hi_run;
    logic [7:0]  edge_cnt;
    logic        sclk_q;

    // Track the serial clock history: last value, high-run length, rise count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            hi_run   <= '0;
            edge_cnt <= '0;
        end else begin
            sclk_q   <= sclk_o;
            hi_run   <= sclk_o ? hi_run + 1'b1 : '0;
            if (csn_o) begin
                edge_cnt <= '0;
            end else if (sclk_o && !sclk_q) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    p_sdo_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sdo_o);

    p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !csn_o);

    p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> (edge_cnt == 8'd24));

    p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == 16'(DIV_HALF)));

    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_o |-> busy_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(csn_o));

endmodule

bind tscm_master tscm_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_o (sclk_o),
    .csn_o  (csn_o),
    .sdo_o  (sdo_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/tscm_master_tb.sv
// Bench: sweeps every command combination in both timing modes against a
// behavioural converter model, plus corner result patterns and a busy poke.
module tscm_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DH = 2;
    localparam int GAP = 5;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic        mode_i = 1'b0;
    logic        ref_sel_i = 1'b0;
    logic [1:0]  pd_i = '0;
    logic        burst_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [11:0] result_o;
    logic        sclk_o;
    logic        csn_o;
    logic        sdo_o;
    logic        sdi_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    tscm_master #(.DIV_HALF(DH), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .chan_i(chan_i), .mode_i(mode_i),
        .ref_sel_i(ref_sel_i), .pd_i(pd_i), .burst_i(burst_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o), .sclk_o(sclk_o), .csn_o(csn_o),
        .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Converter model: takes the command, then shifts out the pattern after
    // the busy clock; drives filler ones at every position outside the window.
    logic [11:0] s_pat = '0;
    logic [7:0]  s_cmd = '0;
    int          s_cnt = 0;
    logic        s_prev_csn = 1'b1;
    logic        s_prev_sclk = 1'b0;
    always @(csn_o or sclk_o) begin
        if (csn_o) begin
            s_cnt = 0;
            sdi_i = 1'b0;
        end else if (s_prev_csn) begin
            s_cnt = 0;
            s_cmd = '0;
            sdi_i = 1'b1;
        end else if (sclk_o && !s_prev_sclk) begin
            s_cnt++;
            if (s_cnt <= 8) s_cmd = {s_cmd[6:0], sdo_o};
        end else if (!sclk_o && s_prev_sclk) begin
            sdi_i = (s_cnt >= 9 && s_cnt <= 20) ? s_pat[20 - s_cnt] : 1'b1;
        end
        s_prev_csn = csn_o;
        s_prev_sclk = sclk_o;
    end

    // Port monitor sampled on the falling system clock edge.
    int   m_rises, m_lowrun, m_hirun, m_maxlow, m_gaps, m_setup, m_tail, m_hibad, m_sdobad;
    logic m_prev_sclk = 1'b0;
    logic m_prev_csn = 1'b1;
    logic m_prev_sdo = 1'b0;
    always @(negedge clk) begin
        if (!csn_o) begin
            if (m_prev_csn) begin
                m_rises = 0; m_lowrun = 0; m_hirun = 0; m_maxlow = 0;
                m_gaps = 0; m_setup = 0; m_hibad = 0; m_sdobad = 0;
            end
            if (sclk_o) begin
                if (!m_prev_sclk) begin
                    if (m_rises == 0) m_setup = m_lowrun;
                    else begin
                        if (m_lowrun > m_maxlow) m_maxlow = m_lowrun;
                        if (m_lowrun > DH) m_gaps++;
                    end
                    m_lowrun = 0;
                    m_rises++;
                end else if (sdo_o != m_prev_sdo) m_sdobad++;
                m_hirun++;
            end else begin
                if (m_prev_sclk && m_hirun != DH) m_hibad++;
                m_hirun = 0;
                m_lowrun++;
            end
        end else if (!m_prev_csn) begin
            m_tail = m_lowrun;
        end
        m_prev_csn = csn_o;
        m_prev_sclk = sclk_o;
        m_prev_sdo = sdo_o;
    end

    task automatic run_frame(input logic [2:0] ch, input logic md, input logic rs,
                             input logic [1:0] pd, input logic bu, input logic [11:0] pat,
                             input bit poke);
        logic [7:0] exp_cmd;
        bit got;
        exp_cmd = {1'b1, ch, md, rs, pd};
        s_pat = pat;
        @(negedge clk);
        chan_i = ch; mode_i = md; ref_sel_i = rs; pd_i = pd; burst_i = bu; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(busy_o == 1'b1, "R8 busy during frame", busy_o, 1);
            chan_i = ~ch; mode_i = ~md; pd_i = ~pd; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_o) begin
                got = 1;
                break;
            end
        end
        chk(got, "R9 done seen", got, 1);
        #1;
        chk(s_cmd == exp_cmd, "R2 command word", s_cmd, exp_cmd);
        chk(m_sdobad == 0, "R2 sdo stable while sclk high", m_sdobad, 0);
        chk(result_o == pat, "R6 R7 result word", result_o, pat);
        chk(m_rises == 24, "R3 rising edge count", m_rises, 24);
        chk(m_setup >= DH && m_tail >= DH, "R3 select setup/hold", m_setup * 256 + m_tail, DH);
        chk(m_hibad == 0, "R4 high phase length", m_hibad, 0);
        if (bu) begin
            chk(m_maxlow == DH + GAP && m_gaps == 2, "R5 burst gaps", m_maxlow * 16 + m_gaps,
                (DH + GAP) * 16 + 2);
        end else begin
            chk(m_maxlow == DH && m_gaps == 0, "R4 continuous low phases", m_maxlow * 16 + m_gaps,
                DH * 16);
        end
        chk(csn_o == 1'b1 && busy_o == 1'b0, "R9 R8 done with select released",
            {csn_o, busy_o}, 2);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        chk(result_o == pat, "R9 result held", result_o, pat);
        if (poke) begin
            got = 1;
            for (int i = 0; i < 4 * DH + 4; i++) begin
                @(negedge clk);
                if (!csn_o) got = 0;
            end
            chk(got, "R8 request while busy started no frame", got, 1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csn_o == 1'b1 && sclk_o == 1'b0 && sdo_o == 1'b0, "R1 link idle",
            {csn_o, sclk_o, sdo_o}, 4);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags low", {busy_o, done_o}, 0);
        chk(result_o == 12'h000, "R1 result zero", result_o, 0);

        // Full sweep of the command fields in both timing modes.
        for (int c = 0; c < 128; c++) begin
            for (int b = 0; b < 2; b++) begin
                logic [6:0] f;
                f = 7'(c);
                run_frame(f[6:4], f[3], f[2], f[1:0], b[0],
                          12'((c * 12'h1B7) ^ (b * 12'h925) ^ 12'hA5C), 1'b0);
            end
        end

        // Corner result words that expose capture-window misalignment (R6, R7).
        run_frame(3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 12'h000, 1'b0);
        run_frame(3'd5, 1'b1, 1'b0, 2'd0, 1'b1, 12'hFFF, 1'b0);
        run_frame(3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 12'h800, 1'b0);
        run_frame(3'd4, 1'b1, 1'b1, 2'd1, 1'b1, 12'h001, 1'b0);
        run_frame(3'd6, 1'b0, 1'b1, 2'd0, 1'b0, 12'hAAA, 1'b0);
        run_frame(3'd2, 1'b1, 1'b0, 2'd3, 1'b1, 12'h555, 1'b0);

        // Requests raised while busy (R8), in both modes.
        run_frame(3'd1, 1'b0, 1'b0, 2'd1, 1'b0, 12'h3C6, 1'b1);
        run_frame(3'd5, 1'b1, 1'b1, 2'd2, 1'b1, 12'hC39, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule